// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a binary counter, four bits wide by default, that moves on strobe edges rather than on a direction bit. It has one input strobe that counts up and a second that counts down. Both strobes idle high. A counting edge is a low-to-high transition on one strobe while the other strobe stays high. The block runs on a single system clock. Each strobe passes through a two-flop synchronizer, and rising edges are found by comparing the synchronized level with its value on the previous cycle.

Two level-sensitive controls override counting. An active-high clear forces the count to zero. An active-low preset copies a data word into the count. Clear wins over preset, and preset wins over any strobe activity. On the first cycle after either control is released, a strobe edge is discarded, so the release cannot also take a count.

Two active-low limit outputs copy the low phase of the active strobe when the count sits at a limit. The carry output follows the up strobe at the all-ones count. The borrow output follows the down strobe at zero. Because these outputs copy the strobe waveforms, they can drive the strobes of a further stage directly. This builds a wider counter as a ripple chain.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge of `up_stb_i` while `dn_stb_i` is high increments `count_o` by one. The new value appears on the third system clock edge after the strobe is first high at an edge.
- R2: A rising edge of `dn_stb_i` while `up_stb_i` is high decrements `count_o` by one, with the same latency as R1.
- R3: Counting wraps modulo 2^WIDTH. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R4: While `clear_i` is high, `count_o` becomes 0 on the next clock edge, whatever the strobes and `load_n_i` are doing.
- R5: While `load_n_i` is low and `clear_i` is low, `count_o` takes the value of `data_i` on the next clock edge, whatever the strobes are doing.
- R6: `carry_n_o` is low only when `count_o` is all ones and the synchronized up strobe is low. It returns high when the synchronized up strobe returns high.
- R7: `borrow_n_o` is low only when `count_o` is 0 and the synchronized down strobe is low.
- R8: If both strobes rise on the same cycle, or if one strobe rises while the other is low, the count does not change.
- R9: On the first cycle after `clear_i` or a low `load_n_i` is released, a strobe edge is ignored.
- R10: Feeding `carry_n_o` and `borrow_n_o` of one stage into `up_stb_i` and `dn_stb_i` of the next stage gives a wider counter that counts correctly across stages.
- R11: While `rst_n` is low at a clock edge, the count and the edge history are cleared. After that reset, `count_o` is 0 and both limit outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_stb_i | input | 1 | Count-up strobe, idles high, counts on its rising edge |
| dn_stb_i | input | 1 | Count-down strobe, idles high, counts on its rising edge |
| clear_i | input | 1 | Active-high clear, highest priority |
| load_n_i | input | 1 | Active-low preset enable |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low up limit, copies the up strobe low phase at all ones |
| borrow_n_o | output | 1 | Active-low down limit, copies the down strobe low phase at zero |

## Verification
The embedded assertions check on every cycle that the clear and preset priorities hold and that the count never moves by more than one step. They also check that conflicting edges and edges during a release produce no step, and that each limit output is low only at its own limit value. Some properties need a controlled sequence of stimulus. These are the exact latency through the synchronizer, wrap-around in both directions, and the release-cycle discard with an edge timed onto that cycle. Correct carry propagation through a two-stage ripple cascade is also in this group. Only the directed scenarios of the bench can show these.

// File: rtl/updn_cnt_pkg.sv
// Package: shared action encoding for the dual-strobe counter.
// Assumes: every module of the counter imports this package.
package updn_cnt_pkg;

    // Action the count register performs on the next clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_INC   = 3'd1,
        ACT_DEC   = 3'd2,
        ACT_CLEAR = 3'd3,
        ACT_LOAD  = 3'd4
    } cnt_act_e;

endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Passes an asynchronous strobe through a chain of flops and flags its rising edge.
// Assumes: the strobe idles high, so the chain resets to ones and reset creates no false edge.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic level_o,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    // The first stage samples the raw strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= strobe_i;
    end

    // Each later stage copies the stage before it.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Hold the synchronized level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[LAST];
    end

    assign level_o = chain_q[LAST];
    assign rise_o  = chain_q[LAST] & ~prev_q;

    // A rise is a one-cycle pulse, never on two cycles in a row (supports R1, R2).
    assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/step_ctrl.sv
// Module: step_ctrl
// Picks the action for the count register: clear, preset, step up, step down, or hold.
// Assumes: clear_i and load_n_i are synchronous to clk. Strobe levels and rises come from strobe_sync.
module step_ctrl
    import updn_cnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear_i,
    input  logic     load_n_i,
    input  logic     up_lvl_i,
    input  logic     up_rise_i,
    input  logic     dn_lvl_i,
    input  logic     dn_rise_i,
    output cnt_act_e act_o
);
    logic override;
    logic block_q;
    logic up_ok;
    logic dn_ok;

    assign override = clear_i | ~load_n_i;
    assign up_ok    = up_rise_i & ~dn_rise_i & dn_lvl_i;
    assign dn_ok    = dn_rise_i & ~up_rise_i & up_lvl_i;

    // Remember whether an override was active so the release cycle takes no count.
    always_ff @(posedge clk) begin
        if (!rst_n) block_q <= 1'b0;
        else        block_q <= override;
    end

    // Priority: clear, then preset, then the release block, then a valid edge.
    always_comb begin
        if (clear_i)        act_o = ACT_CLEAR;
        else if (!load_n_i) act_o = ACT_LOAD;
        else if (block_q)   act_o = ACT_HOLD;
        else if (up_ok)     act_o = ACT_INC;
        else if (dn_ok)     act_o = ACT_DEC;
        else                act_o = ACT_HOLD;
    end

    // Edges on both strobes together never step the count.
    assert_both_rise_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise_i && dn_rise_i) |-> (act_o != ACT_INC && act_o != ACT_DEC));
    // An edge on the cycle right after an override is released never steps.
    assert_release_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && $past(clear_i || !load_n_i)) |-> act_o == ACT_HOLD);
    // A step up needs the down strobe high.
    assert_inc_needs_dn_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o == ACT_INC) |-> dn_lvl_i);
endmodule

// File: rtl/count_reg.sv
// Module: count_reg
// Holds the count and applies the chosen action on each system clock edge.
// Assumes: the action arrives from step_ctrl in the same cycle.
module count_reg
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_act_e         act_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] count_q;

    // Update the count; the add and subtract wrap by width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (act_i)
                ACT_CLEAR: count_q <= '0;
                ACT_LOAD:  count_q <= data_i;
                ACT_INC:   count_q <= count_q + ONE;
                ACT_DEC:   count_q <= count_q - ONE;
                default:   count_q <= count_q;
            endcase
        end
    end

    assign count_o = count_q;

    // The count moves by at most one step unless it is cleared or preset.
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i != ACT_CLEAR && act_i != ACT_LOAD) |=>
        (count_o == $past(count_o) || count_o == $past(count_o) + ONE ||
         count_o == $past(count_o) - ONE));
endmodule

// File: rtl/limit_gen.sv
// Module: limit_gen
// Forms the active-low carry and borrow outputs from the count and the synchronized strobe levels.
// Assumes: the outputs are combinational, so they add no register delay to a cascade.
module limit_gen #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] count_i,
    input  logic             up_lvl_i,
    input  logic             dn_lvl_i,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Copy the low phase of each strobe at its limit.
    always_comb begin
        carry_n_o  = ~((count_i == TOP) & ~up_lvl_i);
        borrow_n_o = ~((count_i == '0)  & ~dn_lvl_i);
    end

    // Carry is low only at the all-ones count.
    assert_carry_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_i == TOP && !up_lvl_i));
    // Carry stays high while the up strobe is high.
    assert_carry_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        up_lvl_i |-> carry_n_o);
    // Borrow is low only at the zero count.
    assert_borrow_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_i == '0 && !dn_lvl_i));
endmodule

// File: rtl/updn_strobe_counter.sv
// Module: updn_strobe_counter
// Top of the dual-strobe presettable up/down counter with ripple-cascade limit outputs.
// Assumes: one system clock; clear_i, load_n_i and data_i are synchronous to it; strobes may be asynchronous.
module updn_strobe_counter
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_stb_i,
    input  logic             dn_stb_i,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    logic     up_lvl, up_rise, dn_lvl, dn_rise;
    cnt_act_e act;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .strobe_i(up_stb_i),
        .level_o(up_lvl), .rise_o(up_rise)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .strobe_i(dn_stb_i),
        .level_o(dn_lvl), .rise_o(dn_rise)
    );

    step_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
        .up_lvl_i(up_lvl), .up_rise_i(up_rise), .dn_lvl_i(dn_lvl), .dn_rise_i(dn_rise),
        .act_o(act)
    );

    count_reg #(.WIDTH(WIDTH)) u_count (
        .clk(clk), .rst_n(rst_n), .act_i(act), .data_i(data_i), .count_o(count_o)
    );

    limit_gen #(.WIDTH(WIDTH)) u_limit (
        .clk(clk), .rst_n(rst_n), .count_i(count_o), .up_lvl_i(up_lvl), .dn_lvl_i(dn_lvl),
        .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
    );

    // Clear forces zero on the next edge.
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> count_o == '0);
    // Preset copies the data word when clear is inactive.
    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_n_i) |=> count_o == $past(data_i));
endmodule

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb;
    localparam int W       = 4;
    localparam int NSTAGE  = 2;
    localparam int GAP     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_stb = 1'b1, dn_stb = 1'b1, clr = 1'b0, ld_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt;
    logic carry_n, borrow_n;

    logic c_up = 1'b1, c_dn = 1'b1, c_clr = 1'b0;
    logic [NSTAGE:0] c_up_chain, c_dn_chain;
    logic [W-1:0] c_cnt [NSTAGE];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updn_strobe_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .up_stb_i(up_stb), .dn_stb_i(dn_stb),
        .clear_i(clr), .load_n_i(ld_n), .data_i(din),
        .count_o(cnt), .carry_n_o(carry_n), .borrow_n_o(borrow_n)
    );

    // Ripple cascade for R10: each stage is driven by the limit outputs of the stage below.
    assign c_up_chain[0] = c_up;
    assign c_dn_chain[0] = c_dn;
    generate
        for (genvar s = 0; s < NSTAGE; s++) begin : g_casc
            updn_strobe_counter #(.WIDTH(W)) u_stage (
                .clk(clk), .rst_n(rst_n), .up_stb_i(c_up_chain[s]), .dn_stb_i(c_dn_chain[s]),
                .clear_i(c_clr), .load_n_i(1'b1), .data_i('0),
                .count_o(c_cnt[s]), .carry_n_o(c_up_chain[s+1]), .borrow_n_o(c_dn_chain[s+1])
            );
        end
    endgenerate

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preset(input logic [W-1:0] v);
        @(negedge clk); din = v; ld_n = 1'b0;
        @(negedge clk); ld_n = 1'b1;
        wait_n(2);
    endtask

    task automatic pulse_up();
        @(negedge clk); up_stb = 1'b0; wait_n(GAP);
        up_stb = 1'b1; wait_n(GAP);
    endtask

    task automatic pulse_dn();
        @(negedge clk); dn_stb = 1'b0; wait_n(GAP);
        dn_stb = 1'b1; wait_n(GAP);
    endtask

    task automatic t_reset();
        chk("R11 count", cnt, 0);
        chk("R11 carry_n", carry_n, 1);
        chk("R11 borrow_n", borrow_n, 1);
    endtask

    task automatic t_count_latency();
        preset(4'd3);
        @(negedge clk); up_stb = 1'b0; wait_n(GAP);
        up_stb = 1'b1;                       // high at the next posedge (edge 1)
        wait_n(2);                           // after edges 1 and 2
        chk("R1 not yet", cnt, 3);
        wait_n(1);                           // after edge 3
        chk("R1 increment", cnt, 4);
        pulse_dn();
        chk("R2 decrement", cnt, 3);
        pulse_dn();
        chk("R2 decrement again", cnt, 2);
    endtask

    task automatic t_wrap_and_limits();
        preset(4'd15);
        @(negedge clk); dn_stb = 1'b0; wait_n(GAP);
        chk("R6 carry high on down strobe", carry_n, 1);
        dn_stb = 1'b1; wait_n(GAP);
        chk("R2 down from 15", cnt, 14);
        preset(4'd15);
        @(negedge clk); up_stb = 1'b0; wait_n(GAP);
        chk("R6 carry low at top", carry_n, 0);
        chk("R7 borrow high at top", borrow_n, 1);
        up_stb = 1'b1; wait_n(GAP);
        chk("R6 carry back high", carry_n, 1);
        chk("R3 wrap up", cnt, 0);
        @(negedge clk); dn_stb = 1'b0; wait_n(GAP);
        chk("R7 borrow low at zero", borrow_n, 0);
        dn_stb = 1'b1; wait_n(GAP);
        chk("R7 borrow back high", borrow_n, 1);
        chk("R3 wrap down", cnt, 15);
    endtask

    task automatic t_clear_load();
        preset(4'd9);
        @(negedge clk); clr = 1'b1; ld_n = 1'b0; din = 4'd6;
        up_stb = 1'b0; wait_n(GAP); up_stb = 1'b1; wait_n(GAP);
        chk("R4 clear over load and strobe", cnt, 0);
        clr = 1'b0;
        wait_n(1);
        chk("R5 load after clear", cnt, 6);
        din = 4'd10; dn_stb = 1'b0; wait_n(GAP); dn_stb = 1'b1; wait_n(GAP);
        chk("R5 load over strobe", cnt, 10);
        ld_n = 1'b1; wait_n(GAP);
        chk("R5 hold after release", cnt, 10);
    endtask

    task automatic t_conflict();
        preset(4'd7);
        @(negedge clk); up_stb = 1'b0; dn_stb = 1'b0; wait_n(GAP);
        up_stb = 1'b1; dn_stb = 1'b1; wait_n(GAP);
        chk("R8 both rise", cnt, 7);
        @(negedge clk); dn_stb = 1'b0; wait_n(GAP);
        up_stb = 1'b0; wait_n(GAP); up_stb = 1'b1; wait_n(GAP);
        chk("R8 up rise with down low", cnt, 7);
        dn_stb = 1'b1; wait_n(GAP);
        chk("R2 down rise after conflict", cnt, 6);
    endtask

    task automatic t_release();
        @(negedge clk); din = 4'd5; ld_n = 1'b0; up_stb = 1'b0; wait_n(GAP);
        up_stb = 1'b1;                        // high at posedge k
        @(posedge clk); @(posedge clk);       // k and k+1 with preset active
        @(negedge clk); ld_n = 1'b1;          // edge k+2 sees the rise on the release cycle
        wait_n(GAP);
        chk("R9 edge on release ignored", cnt, 5);
    endtask

    task automatic t_cascade();
        @(negedge clk); c_clr = 1'b1; wait_n(2); c_clr = 1'b0; wait_n(2);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); c_up = 1'b0; wait_n(8); c_up = 1'b1; wait_n(8);
        end
        wait_n(12);
        chk("R10 low stage after 16 up", c_cnt[0], 0);
        chk("R10 high stage after 16 up", c_cnt[1], 1);
        @(negedge clk); c_dn = 1'b0; wait_n(8); c_dn = 1'b1; wait_n(20);
        chk("R10 low stage after down", c_cnt[0], 15);
        chk("R10 high stage after down", c_cnt[1], 0);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_count_latency();
        t_wrap_and_limits();
        t_clear_load();
        t_conflict();
        t_release();
        t_cascade();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule